// File: doc/BRIEF.md
# Masked Packed Absolute-Value Unit

This block is a SIMD execution datapath. It takes a source vector of up to `VEC_W` bits and treats it as packed signed elements of 8, 16, 32 or 64 bits. It returns the magnitude of each element as an unsigned number. A per-element write mask decides which elements take the new value. Elements whose mask bit is clear either keep the old destination contents (merge) or are cleared (zero). For 32- and 64-bit elements fetched from memory, a broadcast option feeds element 0 to every lane.

An active-length select limits the operation to the low 128, 256 or 512 bits. In the normal modes, everything above that length is cleared. A legacy mode fixes the length at 128 bits, keeps the old destination above bit 127, and turns off masking and broadcast. A 4-bit spare specifier field must be all ones. Any other value raises an illegal-encoding flag instead of producing a result.

The unit has one registered stage. A result appears one clock after `in_valid`, with `out_valid` set.

Top module: `vabs_unit`

## Requirements
- R1: Element size is selected by `esize`: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit. Element j occupies bits [j*EW +: EW]. Each written element holds the absolute value of its signed source element, read as unsigned.
- R2: The most negative value of each width (0x80, 0x8000, ...) comes out as the same bit pattern, which is the magnitude 2^(EW-1). There is no saturation and no flag.
- R3: When `mask_en` is 0, or mask bit j is 1, element j receives the absolute value.
- R4: When `mask_en` is 1 and mask bit j is 0, element j keeps `prev_dst` if `zero_mode` is 0, and becomes zero if `zero_mode` is 1.
- R5: When `bcast` and `src_is_mem` are both 1 with 32- or 64-bit elements, every active written lane receives the absolute value of source element 0. When `src_is_mem` is 0, `bcast` has no effect.
- R6: With 8- or 16-bit elements, `bcast` has no effect and the lanes are processed normally.
- R7: When `legacy` is 0, `vlen` selects the active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits, limited to `VEC_W`. All result bits at or above the active length are zero.
- R8: When `legacy` is 1, the active length is 128 bits. Result bits at and above bit 128 equal `prev_dst`. `mask_en`, `mask`, `zero_mode`, `bcast` and `vlen` have no effect.
- R9: When `in_valid` is 1 and `spare_spec` is not 4'b1111, `illegal` is 1 in the next cycle, `out_valid` stays 0 and `result` keeps its previous value.
- R10: Only the low (active length / EW) bits of `mask` are used. Mask bits above the element count have no effect.
- R11: A legal request gives `result` and `out_valid`=1 exactly one clock later. Without `in_valid`, `out_valid` and `illegal` are 0 and `result` holds. A synchronous active-low reset clears `result`, `out_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| src | input | VEC_W | Packed signed source elements |
| prev_dst | input | VEC_W | Previous destination value |
| esize | input | 2 | Element size code |
| vlen | input | 2 | Active vector length code |
| mask | input | VEC_W/8 | Per-element write mask |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1 = zero masked-off elements, 0 = merge |
| bcast | input | 1 | Broadcast element 0 request |
| src_is_mem | input | 1 | Source operand comes from memory |
| legacy | input | 1 | Legacy 128-bit mode |
| spare_spec | input | 4 | Spare register specifier, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| result | output | VEC_W | Registered result |
| illegal | output | 1 | Illegal-encoding flag |

## Verification
The bench builds the unit with the default `VEC_W` of 512. This brings all three active lengths within reach, including the 512-bit case where no bits lie above the active length. It also uses the full 64-bit byte mask, so that upper mask bits can be shown to be ignored for wide elements and short lengths. All four lane widths are instantiated as banks at this width, so every size and broadcast combination is observable at the `result` port.

// File: rtl/vabs_pkg.sv
package vabs_pkg;
   typedef enum logic [1:0] {
      ESZ_B8  = 2'd0,
      ESZ_B16 = 2'd1,
      ESZ_B32 = 2'd2,
      ESZ_B64 = 2'd3
   } esz_e;

   localparam logic [3:0] SPARE_LEGAL = 4'hF;
   localparam int unsigned LEGACY_BYTES = 16;
   localparam int unsigned NUM_SIZES = 4;
endpackage

// File: rtl/vabs_abs_bank.sv
// One bank of equal-width lanes, each returning |x| as unsigned.
module vabs_abs_bank #(
   parameter int unsigned VEC_W    = 512,
   parameter int unsigned EW       = 8,
   parameter bit          BCAST_OK = 1'b0
) (
   input  logic [VEC_W-1:0] src,
   input  logic             bcast_sel,
   output logic [VEC_W-1:0] abs_out
);
   localparam int unsigned LANES = VEC_W / EW;
   localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

   if ((VEC_W % EW) != 0) begin : g_bad_width
      $error("vabs_abs_bank: VEC_W must be a multiple of EW");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [EW-1:0] lane_in;
      if (BCAST_OK) begin : g_bc
         assign lane_in = bcast_sel ? src[EW-1:0] : src[i*EW +: EW];
      end else begin : g_nobc
         assign lane_in = src[i*EW +: EW];
      end
      assign abs_out[i*EW +: EW] = lane_in[EW-1] ? (~lane_in + ONE) : lane_in;
   end

   if (!BCAST_OK) begin : g_unused
      logic unused_bcast;
      assign unused_bcast = bcast_sel;
   end
endmodule

// File: rtl/vabs_byte_ctl.sv
// Per-byte steering: take the new value, keep prev_dst, or clear.
module vabs_byte_ctl
   import vabs_pkg::*;
#(
   parameter int unsigned VEC_W = 512
) (
   input  logic [1:0]         esize,
   input  logic [1:0]         vlen,
   input  logic               legacy,
   input  logic               mask_en,
   input  logic               zero_mode,
   input  logic [VEC_W/8-1:0] mask,
   output logic [VEC_W/8-1:0] sel_abs,
   output logic [VEC_W/8-1:0] sel_prev
);
   localparam int unsigned NB = VEC_W / 8;

   int unsigned lim_bytes;

   always_comb begin
      int unsigned raw;
      if (legacy) begin
         raw = LEGACY_BYTES;
      end else begin
         case (vlen)
            2'd0:    raw = 16;
            2'd1:    raw = 32;
            default: raw = 64;
         endcase
      end
      lim_bytes = (raw > NB) ? NB : raw;
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic mbit;
      logic on;
      logic in_range;
      always_comb begin
         case (esz_e'(esize))
            ESZ_B8:  mbit = mask[b];
            ESZ_B16: mbit = mask[b/2];
            ESZ_B32: mbit = mask[b/4];
            default: mbit = mask[b/8];
         endcase
      end
      assign in_range    = (b < lim_bytes);
      assign on          = legacy | ~mask_en | mbit;
      assign sel_abs[b]  = in_range & on;
      assign sel_prev[b] = in_range ? (~on & ~zero_mode) : legacy;
   end
endmodule

// File: rtl/vabs_unit.sv
module vabs_unit
   import vabs_pkg::*;
#(
   parameter int unsigned VEC_W = 512
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [VEC_W-1:0]   src,
   input  logic [VEC_W-1:0]   prev_dst,
   input  logic [1:0]         esize,
   input  logic [1:0]         vlen,
   input  logic [VEC_W/8-1:0] mask,
   input  logic               mask_en,
   input  logic               zero_mode,
   input  logic               bcast,
   input  logic               src_is_mem,
   input  logic               legacy,
   input  logic [3:0]         spare_spec,
   output logic               out_valid,
   output logic [VEC_W-1:0]   result,
   output logic               illegal
);
   localparam int unsigned NB = VEC_W / 8;

   if ((VEC_W % 64) != 0 || VEC_W < 128) begin : g_bad_vec
      $error("vabs_unit: VEC_W must be a multiple of 64 and at least 128");
   end

   logic             legal;
   logic             bc_eff;
   logic [VEC_W-1:0] abs_all [NUM_SIZES];
   logic [VEC_W-1:0] picked;
   logic [VEC_W-1:0] next_res;
   logic [NB-1:0]    sel_abs;
   logic [NB-1:0]    sel_prev;

   assign legal  = (spare_spec == SPARE_LEGAL);
   assign bc_eff = bcast & src_is_mem & ~legacy;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
      vabs_abs_bank #(
         .VEC_W   (VEC_W),
         .EW      (8 << s),
         .BCAST_OK(s >= 2)
      ) bank_i (
         .src      (src),
         .bcast_sel(bc_eff),
         .abs_out  (abs_all[s])
      );
   end

   assign picked = abs_all[esize];

   vabs_byte_ctl #(.VEC_W(VEC_W)) ctl_i (
      .esize    (esize),
      .vlen     (vlen),
      .legacy   (legacy),
      .mask_en  (mask_en),
      .zero_mode(zero_mode),
      .mask     (mask),
      .sel_abs  (sel_abs),
      .sel_prev (sel_prev)
   );

   for (genvar b = 0; b < NB; b++) begin : g_mux
      assign next_res[b*8 +: 8] = sel_abs[b]  ? picked[b*8 +: 8]   :
                                  sel_prev[b] ? prev_dst[b*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid & legal;
         illegal   <= in_valid & ~legal;
         if (in_valid && legal) begin
            result <= next_res;
         end
      end
   end
endmodule

// File: rtl/vabs_unit_chk.sv
module vabs_unit_chk #(
   parameter int unsigned VEC_W = 512
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [VEC_W-1:0]   src,
   input logic [VEC_W-1:0]   prev_dst,
   input logic [1:0]         esize,
   input logic [1:0]         vlen,
   input logic [VEC_W/8-1:0] mask,
   input logic               mask_en,
   input logic               zero_mode,
   input logic               legacy,
   input logic [3:0]         spare_spec,
   input logic               out_valid,
   input logic [VEC_W-1:0]   result,
   input logic               illegal
);
   p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && spare_spec == 4'hF) |=> (out_valid && !illegal));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid) |=> (!out_valid && !illegal && $stable(result)));

   p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && spare_spec != 4'hF) |=> (illegal && !out_valid && $stable(result)));

   p_legacy_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && spare_spec == 4'hF && legacy)
      |=> (result[VEC_W-1:128] == $past(prev_dst[VEC_W-1:128])));

   if (VEC_W > 128) begin : g_upper
      p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && spare_spec == 4'hF && !legacy && vlen == 2'd0)
         |=> (result[VEC_W-1:128] == '0));
   end

   p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && spare_spec == 4'hF && !legacy && mask_en && zero_mode && !mask[0])
      |=> (result[7:0] == 8'h00));

   p_merge_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && spare_spec == 4'hF && !legacy && mask_en && !zero_mode
       && !mask[0] && esize == 2'd0)
      |=> (result[7:0] == $past(prev_dst[7:0])));

   logic unused_chk;
   assign unused_chk = ^src;
endmodule

bind vabs_unit vabs_unit_chk #(.VEC_W(VEC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
   .prev_dst(prev_dst), .esize(esize), .vlen(vlen), .mask(mask),
   .mask_en(mask_en), .zero_mode(zero_mode), .legacy(legacy),
   .spare_spec(spare_spec), .out_valid(out_valid), .result(result),
   .illegal(illegal)
);

// File: tb/vabs_unit_tb_top.sv
`timescale 1ns/1ps
module vabs_unit_tb_top;
   localparam int VW = 512;
   localparam int MW = VW / 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [VW-1:0] src, prev_dst;
   logic [1:0]    esize, vlen;
   logic [MW-1:0] mask;
   logic          mask_en, zero_mode, bcast, src_is_mem, legacy;
   logic [3:0]    spare_spec;
   logic          out_valid, illegal;
   logic [VW-1:0] result;

   int checks = 0;
   int errors = 0;
   logic [VW-1:0] last_good = '0;

   always #2 clk = ~clk;

   vabs_unit #(.VEC_W(VW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
      .prev_dst(prev_dst), .esize(esize), .vlen(vlen), .mask(mask),
      .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
      .src_is_mem(src_is_mem), .legacy(legacy), .spare_spec(spare_spec),
      .out_valid(out_valid), .result(result), .illegal(illegal)
   );

   function automatic logic [VW-1:0] model(
      input logic [VW-1:0] s, input logic [VW-1:0] p, input logic [1:0] es,
      input logic [1:0] vl, input logic [MW-1:0] m, input logic men,
      input logic zm, input logic bc, input logic mem, input logic leg);
      logic [VW-1:0] r = '0;
      int ew = 8 << es;
      int act = leg ? 128 : (vl == 2'd0 ? 128 : (vl == 2'd1 ? 256 : 512));
      bit bon = bc && mem && !leg && es >= 2;
      logic [63:0] lm = (64'h1 << ew) - 64'h1;
      for (int e = 0; e < VW / ew; e++) begin
         int base = e * ew;
         logic [63:0] x = '0;
         logic [63:0] y;
         for (int k = 0; k < ew; k++) x[k] = bon ? s[k] : s[base + k];
         if (x[ew-1]) x = (~x + 64'h1) & lm;
         for (int k = 0; k < ew; k++) begin
            if (base >= act)                   y[k] = leg ? p[base + k] : 1'b0;
            else if (leg || !men || m[e])      y[k] = x[k];
            else                               y[k] = zm ? 1'b0 : p[base + k];
            r[base + k] = y[k];
         end
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk(input string tag, input logic cond, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [VW-1:0] s, input logic [VW-1:0] p,
                      input logic [1:0] es, input logic [1:0] vl, input logic [MW-1:0] m,
                      input logic men, input logic zm, input logic bc, input logic mem,
                      input logic leg, input logic [3:0] sp);
      logic [VW-1:0] exp;
      @(negedge clk);
      src = s; prev_dst = p; esize = es; vlen = vl; mask = m; mask_en = men;
      zero_mode = zm; bcast = bc; src_is_mem = mem; legacy = leg; spare_spec = sp;
      in_valid = 1'b1;
      exp = (sp == 4'hF) ? model(s, p, es, vl, m, men, zm, bc, mem, leg) : last_good;
      @(negedge clk);
      in_valid = 1'b0;
      if (sp == 4'hF) begin
         chk(tag, out_valid === 1'b1 && illegal === 1'b0, "valid/illegal",
             {510'd0, out_valid, illegal}, {510'd0, 2'b10});
         chk(tag, result === exp, "result", result, exp);
         last_good = exp;
      end else begin
         chk(tag, out_valid === 1'b0 && illegal === 1'b1, "valid/illegal",
             {510'd0, out_valid, illegal}, {510'd0, 2'b01});
         chk(tag, result === exp, "held result", result, exp);
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [VW-1:0] negs, pv, sv;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; src = '0; prev_dst = '0; esize = 0; vlen = 0;
      mask = '0; mask_en = 0; zero_mode = 0; bcast = 0; src_is_mem = 0; legacy = 0;
      spare_spec = 4'hF;
      repeat (3) @(negedge clk);
      chk("R11", out_valid === 1'b0 && illegal === 1'b0 && result === '0,
          "reset state", result, '0);
      rst_n = 1'b1;

      pv = rnd_vec();
      // R1 R2: most negative pattern of every width, full length, no mask
      for (int s = 0; s < 4; s++) begin
         negs = '0;
         for (int e = 0; e < VW / (8 << s); e++) negs[e*(8<<s) + (8<<s) - 1] = 1'b1;
         run("R2", negs, pv, 2'(s), 2'd2, '0, 0, 0, 0, 0, 0, 4'hF);
         chk("R2", result === negs, "min value kept", result, negs);
      end
      // R1: all sizes, random data
      for (int s = 0; s < 4; s++) run("R1", rnd_vec(), pv, 2'(s), 2'd2, '0, 0, 0, 0, 0, 0, 4'hF);
      // R3 R4: masking merge and zero
      run("R3", rnd_vec(), pv, 2'd0, 2'd2, {32{2'b01}}, 1, 0, 0, 0, 0, 4'hF);
      run("R4", rnd_vec(), pv, 2'd1, 2'd2, {32{2'b10}}, 1, 0, 0, 0, 0, 4'hF);
      run("R4", rnd_vec(), pv, 2'd2, 2'd2, {32{2'b10}}, 1, 1, 0, 0, 0, 4'hF);
      // R5: broadcast 32 and 64 from memory; not from register
      sv = rnd_vec(); sv[31] = 1'b1;
      run("R5", sv, pv, 2'd2, 2'd2, '1, 0, 0, 1, 1, 0, 4'hF);
      run("R5", sv, pv, 2'd3, 2'd1, 64'h5, 1, 1, 1, 1, 0, 4'hF);
      run("R5", sv, pv, 2'd2, 2'd2, '1, 0, 0, 1, 0, 0, 4'hF);
      // R6: broadcast ignored for narrow elements
      run("R6", sv, pv, 2'd0, 2'd2, '1, 0, 0, 1, 1, 0, 4'hF);
      run("R6", sv, pv, 2'd1, 2'd2, '1, 0, 0, 1, 1, 0, 4'hF);
      // R7: short lengths clear upper bits
      run("R7", rnd_vec(), pv, 2'd0, 2'd0, '1, 0, 0, 0, 0, 0, 4'hF);
      run("R7", rnd_vec(), pv, 2'd3, 2'd1, '1, 1, 0, 0, 0, 0, 4'hF);
      run("R7", rnd_vec(), pv, 2'd1, 2'd3, '1, 0, 0, 0, 0, 0, 4'hF);
      // R8: legacy mode ignores mask, broadcast and vlen; upper kept
      run("R8", sv, pv, 2'd2, 2'd2, '0, 1, 1, 1, 1, 1, 4'hF);
      run("R8", rnd_vec(), rnd_vec(), 2'd0, 2'd1, '0, 1, 0, 0, 0, 1, 4'hF);
      // R10: high mask bits ignored (64-bit elements, 256-bit length)
      run("R10", rnd_vec(), pv, 2'd3, 2'd1, {60'hFFFF_FFFF_FFFF_FFF, 4'h0}, 1, 0, 0, 0, 0, 4'hF);
      run("R10", rnd_vec(), pv, 2'd2, 2'd0, {60'hFFFF_FFFF_FFFF_FFF, 4'h6}, 1, 1, 0, 0, 0, 4'hF);
      // R9: bad spare specifier
      run("R9", rnd_vec(), pv, 2'd0, 2'd2, '1, 0, 0, 0, 0, 0, 4'hE);
      run("R9", rnd_vec(), pv, 2'd3, 2'd2, '1, 0, 0, 0, 0, 1, 4'h0);
      // R11: idle cycle holds
      @(negedge clk);
      chk("R11", out_valid === 1'b0 && illegal === 1'b0 && result === last_good,
          "idle hold", result, last_good);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [3:0] sp;
         sv = rnd_vec();
         if ($urandom % 4 == 0) sv[63] = 1'b1;
         sp = ($urandom % 10 == 0) ? 4'($urandom % 15) : 4'hF;
         run("R1", sv, rnd_vec(), 2'($urandom), 2'($urandom),
             {$urandom, $urandom}, 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), ($urandom % 5 == 0), sp);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule